// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This unit holds the status register of a serial flash device and makes every decision about whether a write may go ahead. It keeps four pieces of state:

- a write-enable latch;
- a two-bit block-protect level;
- a protect-enable bit;
- a busy flag.

It combines them with the active-low external write-protect pin to accept or refuse status writes and array writes (program or erase) for a given address.

The command front end drives single-cycle strobes for these events: enable-write, disable-write, status-data load, status-write commit at deselect, and array-cycle start. The sequencer drives a single-cycle pulse when an internal cycle finishes. The unit returns the status byte for status reads. It also returns two permit flags:

- an address-open flag, which depends only on the address and the protect level;
- a status-write permit.

The sequencer can test both before it launches a cycle. The stored non-volatile bits are modelled as plain registers that reset to zero.

Top module: `fsp_status_unit`

## Requirements
- R1: After reset the status byte reads 0x00, and `busy_o` and `wel_o` are 0.
- R2: While idle, the status byte is {protect-enable, 3'b000, level[1:0], write-enable latch, 1'b0}, with protect-enable in bit 7, the level in bits 3..2 and the latch in bit 1.
- R3: While an internal cycle runs, the status byte reads 0xFF.
- R4: `addr_open_o` is 0 when the address is locked, judged on its two top bits. Level 0 locks nothing. Level 1 locks addresses whose top two bits are 11 (0x18000–0x1FFFF at 17 bits). Level 2 locks addresses whose top bit is 1 (0x10000–0x1FFFF). Level 3 locks every address.
- R5: An enable-write strobe sets the latch. A disable-write strobe clears it.
- R6: A status write whose data load arrives while the latch is clear is dropped at commit: no busy, no change to the stored bits.
- R7: When the pin is low and protect-enable is 1, status writes are refused and `sr_ok_o` is 0.
- R8: When protect-enable is 0, a low pin does not stop a status write.
- R9: An accepted status write stores only data bit 7 (protect-enable) and data bits 3..2 (level). Every other data bit is ignored.
- R10: If hardware protection becomes active between data load and commit, the status write is aborted, and a later commit does not revive it. Once the cycle has started, the pin has no effect on it.
- R11: An array-cycle start sets busy only when the latch is set and the address is open. Otherwise it is dropped and the latch is kept.
- R12: The end-of-cycle pulse clears both busy and the latch.
- R13: While busy, every strobe except end-of-cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n_i | input | 1 | Write-protect pin, low = protect |
| wren_i | input | 1 | Enable-write strobe |
| wrdi_i | input | 1 | Disable-write strobe |
| sr_load_i | input | 1 | Status data byte received |
| sr_data_i | input | 8 | Status data byte |
| sr_commit_i | input | 1 | Status write ends (deselect) |
| arr_start_i | input | 1 | Program/erase start request at deselect |
| addr_i | input | ADDR_W | Candidate array address |
| cycle_done_i | input | 1 | End-of-internal-cycle pulse |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Internal cycle running |
| wel_o | output | 1 | Write-enable latch |
| addr_open_o | output | 1 | Address not locked by the protect level |
| sr_ok_o | output | 1 | A status write would be accepted now |

## Verification
Every stored bit, and so `status_o`, `busy_o` and `wel_o`, changes on the first rising edge after the strobe that causes it. The bench drives strobes at a falling edge, holds them for one cycle, and samples at the next falling edge, when the new value is settled. `addr_open_o` and `sr_ok_o` are combinational. They are read half a cycle after the address or pin changes, or once the level or protect-enable bit has been registered. Refusal cases are checked at the next falling edge after the commit or start strobe, where an accepted request would already show busy.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef struct packed {
        logic       wpen;      // protect-enable
        logic [1:0] lvl;       // block-protect level
        logic       wel;       // write-enable latch
        logic       busy;      // internal cycle running
        logic       pend;      // status write armed, awaiting commit
        logic       pend_wpen;
        logic [1:0] pend_lvl;
    } fsp_state_t;

    localparam fsp_state_t FSP_RESET = '0;

    // Lock decision from the two top address bits and the protect level.
    function automatic logic lvl_locks(input logic [1:0] lvl, input logic [1:0] top2);
        logic r;
        case (lvl)
            2'd0:    r = 1'b0;
            2'd1:    r = (top2 == 2'b11);
            2'd2:    r = top2[1];
            default: r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] fmt_status(input fsp_state_t s);
        return s.busy ? 8'hFF : {s.wpen, 3'b000, s.lvl, s.wel, 1'b0};
    endfunction

endpackage

// File: rtl/fsp_lock_map.sv
module fsp_lock_map
    import fsp_pkg::*;
(
    input  logic [1:0] lvl_i,
    input  logic [1:0] top2_i,
    output logic       open_o
);
    always_comb begin
        open_o = ~lvl_locks(lvl_i, top2_i);
    end

    always_comb begin
        if (lvl_i == 2'd3) a_r4_full_lock: assert (!open_o);
        if (lvl_i == 2'd0) a_r4_no_lock:   assert (open_o);
    end
endmodule

// File: rtl/fsp_state.sv
module fsp_state
    import fsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_n_i,
    input  logic       wren_i,
    input  logic       wrdi_i,
    input  logic       sr_load_i,
    input  logic       ld_wpen_i,
    input  logic [1:0] ld_lvl_i,
    input  logic       sr_commit_i,
    input  logic       arr_start_i,
    input  logic       addr_open_i,
    input  logic       done_i,
    output fsp_state_t st_o,
    output logic       hw_prot_o
);
    fsp_state_t st_d, st_q;
    logic       hw;

    always_comb begin
        st_d = st_q;
        hw   = st_q.wpen & ~wp_n_i;
        if (st_q.busy) begin
            st_d.pend = 1'b0;
            if (done_i) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
            end
        end else begin
            if (wren_i) st_d.wel = 1'b1;
            if (wrdi_i) st_d.wel = 1'b0;
            if (sr_load_i) begin
                st_d.pend      = st_q.wel & ~hw;
                st_d.pend_wpen = ld_wpen_i;
                st_d.pend_lvl  = ld_lvl_i;
            end else if (hw) begin
                st_d.pend = 1'b0;
            end
            if (sr_commit_i) begin
                st_d.pend = 1'b0;
                if (st_q.pend && st_q.wel && !hw) begin
                    st_d.wpen = st_q.pend_wpen;
                    st_d.lvl  = st_q.pend_lvl;
                    st_d.busy = 1'b1;
                end
            end
            if (arr_start_i && st_q.wel && addr_open_i) st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FSP_RESET;
        else        st_q <= st_d;
    end

    assign st_o      = st_q;
    assign hw_prot_o = hw;

    a_r11_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(st_q.wel));
    a_r12_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && done_i) |=> (!st_q.busy && !st_q.wel));
    a_r7_hw_blocks_sr: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && hw) |=> $stable({st_q.wpen, st_q.lvl}));
    a_r13_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done_i) |=> (st_q.busy && $stable(st_q.wel) && $stable({st_q.wpen, st_q.lvl})));
    a_r11_locked_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && arr_start_i && !addr_open_i && !sr_commit_i) |=> !st_q.busy);
endmodule

// File: rtl/fsp_status_unit.sv
module fsp_status_unit
    import fsp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              sr_load_i,
    input  logic [7:0]        sr_data_i,
    input  logic              sr_commit_i,
    input  logic              arr_start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              busy_o,
    output logic              wel_o,
    output logic              addr_open_o,
    output logic              sr_ok_o
);
    localparam int TOP_HI = ADDR_W - 1;
    localparam int TOP_LO = ADDR_W - 2;

    fsp_state_t st;
    logic       hw_prot;
    logic       unused_bits;

    assign unused_bits = ^{sr_data_i[6:4], sr_data_i[1:0], addr_i[TOP_LO-1:0]};

    fsp_lock_map u_map (
        .lvl_i  (st.lvl),
        .top2_i (addr_i[TOP_HI:TOP_LO]),
        .open_o (addr_open_o)
    );

    fsp_state u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .wp_n_i      (wp_n_i),
        .wren_i      (wren_i),
        .wrdi_i      (wrdi_i),
        .sr_load_i   (sr_load_i),
        .ld_wpen_i   (sr_data_i[7]),
        .ld_lvl_i    (sr_data_i[3:2]),
        .sr_commit_i (sr_commit_i),
        .arr_start_i (arr_start_i),
        .addr_open_i (addr_open_o),
        .done_i      (cycle_done_i),
        .st_o        (st),
        .hw_prot_o   (hw_prot)
    );

    always_comb begin
        status_o = fmt_status(st);
        busy_o   = st.busy;
        wel_o    = st.wel;
        sr_ok_o  = st.wel & ~st.busy & ~hw_prot;
    end

    a_r3_busy_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (status_o == 8'hFF));
    a_r2_idle_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (status_o[6:4] == 3'b000 && status_o[0] == 1'b0));
endmodule

// File: tb/tb_fsp_status_unit.sv
module tb_fsp_status_unit;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1, wren = 1'b0, wrdi = 1'b0, ld = 1'b0, cm = 1'b0, st = 1'b0, dn = 1'b0;
    logic [7:0]    dat = 8'h00;
    logic [AW-1:0] adr = '0;
    logic [7:0]    status;
    logic          busy, wel, aopen, srok;
    int            checks = 0, errors = 0;

    always #2 clk = ~clk;

    fsp_status_unit #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .wren_i(wren), .wrdi_i(wrdi),
        .sr_load_i(ld), .sr_data_i(dat), .sr_commit_i(cm), .arr_start_i(st),
        .addr_i(adr), .cycle_done_i(dn), .status_o(status), .busy_o(busy),
        .wel_o(wel), .addr_open_o(aopen), .sr_ok_o(srok)
    );

    // {level[1:0], address[16:0], expected open}
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 17'h00000, 1'b1}, {2'd0, 17'h1FFFF, 1'b1},
        {2'd1, 17'h17FFF, 1'b1}, {2'd1, 17'h18000, 1'b0}, {2'd1, 17'h1FFFF, 1'b0},
        {2'd2, 17'h0FFFF, 1'b1}, {2'd2, 17'h10000, 1'b0}, {2'd2, 17'h18000, 1'b0},
        {2'd3, 17'h00000, 1'b0}, {2'd3, 17'h0FFFF, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic sr_write(input logic [7:0] d);
        dat = d;
        pulse(ld);
        pulse(cm);
    endtask

    task automatic set_level(input logic [1:0] l);
        pulse(wren);
        sr_write({4'b0000, l, 2'b00});
        pulse(dn);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset busy/wel", {6'b0, busy, wel}, 8'h00);

        pulse(wren); chk("R5 wren sets latch (R2 layout)", status, 8'h02);
        pulse(wrdi); chk("R5 wrdi clears latch", status, 8'h00);

        sr_write(8'h8C); chk("R6 sr write without latch dropped", status, 8'h00);

        pulse(wren); sr_write(8'hFF);
        chk("R3 busy reads all ones", status, 8'hFF);
        dat = 8'h00; pulse(ld); pulse(cm); pulse(wrdi); pulse(st);
        chk("R13 strobes ignored while busy", {7'b0, busy}, 8'h01);
        pulse(dn);
        chk("R9 R12 R13 only bits 7,3,2 stored, latch cleared", status, 8'h8C);

        wp_n = 1'b0; pulse(wren);
        @(negedge clk); chk("R7 sr_ok low under hw protect", {7'b0, srok}, 8'h00);
        sr_write(8'h00); chk("R7 status write refused", status, 8'h8E);
        pulse(wrdi);

        wp_n = 1'b1; set_level(2'd0);
        chk("R12 status after clearing write", status, 8'h00);
        wp_n = 1'b0; pulse(wren); sr_write(8'h04);
        chk("R8 pin ignored when protect-enable is 0", {7'b0, busy}, 8'h01);
        pulse(dn); chk("R8 level stored", status, 8'h04);

        wp_n = 1'b1; pulse(wren); sr_write(8'h84); pulse(dn);
        chk("R2 wpen and level 1", status, 8'h84);
        pulse(wren); dat = 8'h88; pulse(ld);
        wp_n = 1'b0; @(negedge clk);
        pulse(cm); chk("R10 abort on pin fall before commit", status, 8'h86);
        wp_n = 1'b1; @(negedge clk);
        pulse(cm); chk("R10 aborted write not revived", status, 8'h86);
        sr_write(8'h88); chk("R10 cycle started", {7'b0, busy}, 8'h01);
        wp_n = 1'b0; @(negedge clk); pulse(dn);
        chk("R10 pin fall after start has no effect", status, 8'h88);

        wp_n = 1'b1;
        adr = 17'h00000; pulse(st);
        chk("R11 array start without latch dropped", {7'b0, busy}, 8'h00);
        pulse(wren); adr = 17'h10000; pulse(st);
        chk("R11 locked address dropped, latch kept", status, 8'h8A);
        adr = 17'h0FFFF; pulse(st);
        chk("R11 open address starts cycle", {7'b0, busy}, 8'h01);
        pulse(dn); chk("R12 array cycle done clears latch", status, 8'h88);

        for (int i = 0; i < NV; i++) begin
            set_level(VEC[i][19:18]);
            adr = VEC[i][17:1];
            @(negedge clk);
            chk("R4 lock map", {7'b0, aopen}, {7'b0, VEC[i][0]});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule